// File: doc/BRIEF.md
# Execute-Stage Multicycle Issue Interlock

This controller decides, every cycle, whether the instruction sitting in decode of a five-stage in-order pipeline may move into execute. The execute stage holds three resources with different timing: a single-cycle path for ALU, load/store and branch operations, a multiplier split into four pipelined sub-stages, and an iterative divider that keeps its one stage for four cycles. The controller receives the decoded class of the waiting instruction and a valid bit. It grants issue or raises a stall that freezes fetch and decode while a bubble goes into execute.

The occupancy rules are deliberately lopsided. Multiplies may follow each other on consecutive cycles. While any multiply sits in a multiplier sub-stage, no other class may enter. A divide shuts out every class, multiplies included, until its last execute cycle. Branches are predicted not taken. When a branch in execute turns out taken, the controller raises a flush for fetch and decode and, in the same cycle, presents the redirect target. The flush takes precedence over any stall.

Top module: `ex_issue_ctrl`

## Requirements
- R1: A synchronous active-high reset clears multiplier occupancy and divider busy. In the first cycle after reset, with decode valid low, stall, flush and issue are all low and redirect_pc is zero.
- R2: Class codes 0 (ALU), 1 (load/store) and 2 (branch) issue in the same cycle they are valid when mul_occ is all zero and div_busy is low.
- R3: Class code 3 (multiply) issues whenever it is valid, div_busy is low and no flush is present, whatever the value of mul_occ. After each clock edge, mul_occ bit 0 equals whether a multiply issued, and bit k+1 equals the previous bit k.
- R4: A non-multiply instruction stalls while any mul_occ bit is set. After the last multiply issues it is held for exactly four cycles and issues in the fifth.
- R5: After a divide (class code 4) issues, div_busy is high for the next three cycles and every class stalls during that time. An instruction may issue in the fourth cycle after the divide.
- R6: When dec_valid is low, issue and stall are both low and occupancy does not advance with new entries. Stall equals dec_valid and not issue whenever flush is low.
- R7: A branch that issues in cycle t sits in execute in cycle t+1. If ex_br_taken is high in t+1, flush is high and redirect_pc equals ex_br_target in that cycle. ex_br_taken has no effect in any other cycle, and redirect_pc is zero whenever flush is low.
- R8: During a flush, issue and stall are both low even with dec_valid high. A squashed multiply or divide leaves no occupancy behind.
- R9: The unused class codes 5, 6 and 7 are handled as single-cycle non-multiply instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode holds a valid instruction |
| dec_class | input | 3 | Class of the decode instruction (0 ALU, 1 load/store, 2 branch, 3 multiply, 4 divide) |
| ex_br_taken | input | 1 | Resolved outcome of the branch currently in execute |
| ex_br_target | input | PC_W | Target address of the branch in execute |
| issue | output | 1 | Decode instruction enters execute at the next edge |
| stall | output | 1 | Hold fetch and decode, bubble into execute |
| flush | output | 1 | Clear fetch and decode valid bits |
| redirect_pc | output | PC_W | Fetch redirect address, valid while flush is high |
| mul_occ | output | MUL_STAGES | Multiplier sub-stage occupancy, bit k for sub-stage k |
| div_busy | output | 1 | Divider still holds a divide beyond this cycle |

## Verification
The bench targets the edges of each lockout window. An ALU operation placed directly behind a burst of four multiplies would issue a cycle early if the shift register were one stage short, or a cycle late if it were one stage long. An instruction placed behind a divide shows an off-by-one divider count in the same way, and a multiply behind a divide exposes a design that lets multiplies bypass the divider lock. A taken outcome that arrives without a branch in execute, and a multiply squashed by a flush, catch designs that flush spuriously or leak occupancy from squashed work. A reset applied mid-burst catches occupancy that survives reset.

// File: rtl/exi_pkg.sv
package exi_pkg;
  typedef enum logic [2:0] {
    CLS_ALU = 3'd0,
    CLS_MEM = 3'd1,
    CLS_BR  = 3'd2,
    CLS_MUL = 3'd3,
    CLS_DIV = 3'd4
  } cls_e;
endpackage

// File: rtl/exi_mul_track.sv
module exi_mul_track #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  output logic [STAGES-1:0] occ,
  output logic              any
);
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= push;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= {occ[STAGES-2:0], push};
      end
    end
  endgenerate

  assign any = |occ;
endmodule

// File: rtl/exi_div_track.sv
module exi_div_track #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/exi_branch_unit.sv
module exi_branch_unit #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            br_issue,
  input  logic            taken,
  input  logic [PC_W-1:0] target,
  output logic            flush,
  output logic [PC_W-1:0] redirect_pc
);
  logic br_in_ex;

  always_ff @(posedge clk) begin
    if (rst) br_in_ex <= 1'b0;
    else     br_in_ex <= br_issue;
  end

  assign flush       = br_in_ex & taken;
  assign redirect_pc = flush ? target : '0;
endmodule

// File: rtl/ex_issue_ctrl.sv
module ex_issue_ctrl #(
  parameter int PC_W       = 32,
  parameter int MUL_STAGES = 4,
  parameter int DIV_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dec_valid,
  input  logic [2:0]            dec_class,
  input  logic                  ex_br_taken,
  input  logic [PC_W-1:0]       ex_br_target,
  output logic                  issue,
  output logic                  stall,
  output logic                  flush,
  output logic [PC_W-1:0]       redirect_pc,
  output logic [MUL_STAGES-1:0] mul_occ,
  output logic                  div_busy
);
  import exi_pkg::*;

  logic is_mul, is_div, is_br;
  logic mul_any, may_enter;

  assign is_mul = (dec_class == CLS_MUL);
  assign is_div = (dec_class == CLS_DIV);
  assign is_br  = (dec_class == CLS_BR);

  // Multiplies overlap each other; everything else needs an empty multiplier.
  assign may_enter = !div_busy && (is_mul || !mul_any);
  assign issue     = dec_valid && may_enter && !flush;
  assign stall     = dec_valid && !may_enter && !flush;

  exi_mul_track #(.STAGES(MUL_STAGES)) u_mul (
    .clk  (clk),
    .rst  (rst),
    .push (issue && is_mul),
    .occ  (mul_occ),
    .any  (mul_any)
  );

  exi_div_track #(.CYCLES(DIV_CYCLES)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (issue && is_div),
    .busy  (div_busy)
  );

  exi_branch_unit #(.PC_W(PC_W)) u_br (
    .clk         (clk),
    .rst         (rst),
    .br_issue    (issue && is_br),
    .taken       (ex_br_taken),
    .target      (ex_br_target),
    .flush       (flush),
    .redirect_pc (redirect_pc)
  );
endmodule

// File: rtl/exi_chk.sv
module exi_chk #(
  parameter int MUL_STAGES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  dec_valid,
  input logic [2:0]            dec_class,
  input logic                  issue,
  input logic                  stall,
  input logic                  flush,
  input logic [MUL_STAGES-1:0] mul_occ,
  input logic                  div_busy
);
  // R3
  mul_shift_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mul_occ[MUL_STAGES-1:1] == $past(mul_occ[MUL_STAGES-2:0]));

  // R3
  mul_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_class == 3'd3) |=> mul_occ[0]);

  // R4
  no_mix_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_class != 3'd3) |-> (mul_occ == '0 && !div_busy));

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_class == 3'd4) |=> div_busy);

  // R6
  stall_valid_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> (dec_valid && !issue));

  // R8
  flush_pri_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!stall && !issue));

  // R7
  flush_src_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(issue && dec_class == 3'd2));
endmodule

bind ex_issue_ctrl exi_chk #(.MUL_STAGES(MUL_STAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dec_valid (dec_valid),
  .dec_class (dec_class),
  .issue     (issue),
  .stall     (stall),
  .flush     (flush),
  .mul_occ   (mul_occ),
  .div_busy  (div_busy)
);

// File: tb/sim_ex_issue_ctrl.sv
`timescale 1ns/1ps
module sim_ex_issue_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dec_valid = 1'b0;
  logic [2:0]  dec_class = 3'd0;
  logic        ex_br_taken = 1'b0;
  logic [31:0] ex_br_target = 32'd0;
  logic        issue, stall, flush, div_busy;
  logic [31:0] redirect_pc;
  logic [3:0]  mul_occ;

  always #2.5 clk = ~clk;

  ex_issue_ctrl u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_class(dec_class),
    .ex_br_taken(ex_br_taken), .ex_br_target(ex_br_target),
    .issue(issue), .stall(stall), .flush(flush), .redirect_pc(redirect_pc),
    .mul_occ(mul_occ), .div_busy(div_busy)
  );

  int    n_run = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur = "R1";

  // Behavioural reference: cycle stamps of past issues.
  int cyc;
  int mul_hist[$];
  int div_at;
  int br_at;

  task automatic model_clear();
    cyc = 0;
    mul_hist.delete();
    div_at = -100;
    br_at = -100;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    dec_valid = 1'b0;
    ex_br_taken = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic step(input logic v, input logic [2:0] c, input logic tk,
                      input logic [31:0] tgt);
    logic [3:0]  e_occ;
    logic        e_div, e_flush, e_issue, e_stall, ok;
    logic [31:0] e_pc;
    @(negedge clk);
    dec_valid = v; dec_class = c; ex_br_taken = tk; ex_br_target = tgt;
    #1;
    e_occ = '0;
    for (int k = 0; k < 4; k++)
      foreach (mul_hist[i]) if (mul_hist[i] == cyc - 1 - k) e_occ[k] = 1'b1;
    e_div   = (cyc - div_at >= 1) && (cyc - div_at <= 3);
    e_flush = (br_at == cyc - 1) && tk;
    ok      = !e_div && (c == 3'd3 || e_occ == 4'd0);
    e_issue = v && ok && !e_flush;
    e_stall = v && !ok && !e_flush;
    e_pc    = e_flush ? tgt : 32'd0;
    n_run++;
    if (issue !== e_issue || stall !== e_stall || flush !== e_flush ||
        redirect_pc !== e_pc || mul_occ !== e_occ || div_busy !== e_div) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual issue=%b stall=%b flush=%b pc=%h occ=%b div=%b expected issue=%b stall=%b flush=%b pc=%h occ=%b div=%b",
               cur, cyc, issue, stall, flush, redirect_pc, mul_occ, div_busy,
               e_issue, e_stall, e_flush, e_pc, e_occ, e_div);
    end
    if (e_issue) begin
      if (c == 3'd3) mul_hist.push_back(cyc);
      if (c == 3'd4) div_at = cyc;
      if (c == 3'd2) br_at = cyc;
    end
    cyc++;
  endtask

  task automatic hold(input logic [2:0] c, input int n);
    for (int i = 0; i < n; i++) step(1'b1, c, 1'b0, 32'd0);
  endtask

  initial begin
    model_clear();
    do_reset();
    cur = "R1"; step(1'b0, 3'd0, 1'b0, 32'd0);

    cur = "R2";
    step(1'b1, 3'd0, 1'b0, 32'd0);
    step(1'b1, 3'd1, 1'b0, 32'd0);
    step(1'b1, 3'd2, 1'b0, 32'd0);
    step(1'b1, 3'd0, 1'b0, 32'h40);

    cur = "R6";
    step(1'b0, 3'd3, 1'b0, 32'd0);
    step(1'b0, 3'd4, 1'b0, 32'd0);
    step(1'b0, 3'd0, 1'b0, 32'd0);

    cur = "R3"; hold(3'd3, 4);
    cur = "R4"; hold(3'd0, 6);
    cur = "R4"; step(1'b1, 3'd3, 1'b0, 32'd0); hold(3'd1, 6);

    cur = "R5"; step(1'b1, 3'd4, 1'b0, 32'd0); hold(3'd3, 5);
    cur = "R5"; step(1'b1, 3'd4, 1'b0, 32'd0); hold(3'd0, 5);
    cur = "R5"; step(1'b1, 3'd4, 1'b0, 32'd0); hold(3'd4, 5);
    step(1'b0, 3'd0, 1'b0, 32'd0); step(1'b0, 3'd0, 1'b0, 32'd0);
    step(1'b0, 3'd0, 1'b0, 32'd0);

    cur = "R7";
    step(1'b1, 3'd2, 1'b0, 32'd0);
    step(1'b1, 3'd0, 1'b1, 32'h0000_1234);
    step(1'b1, 3'd0, 1'b1, 32'h0000_5678);
    step(1'b0, 3'd0, 1'b1, 32'h0000_9abc);
    step(1'b1, 3'd2, 1'b0, 32'd0);
    step(1'b0, 3'd0, 1'b0, 32'hdead_beef);

    cur = "R8";
    step(1'b1, 3'd2, 1'b0, 32'd0);
    step(1'b1, 3'd3, 1'b1, 32'h0000_0100);
    step(1'b1, 3'd0, 1'b0, 32'd0);
    step(1'b1, 3'd2, 1'b0, 32'd0);
    step(1'b1, 3'd4, 1'b1, 32'h0000_0200);
    step(1'b1, 3'd0, 1'b0, 32'd0);

    cur = "R9";
    step(1'b1, 3'd3, 1'b0, 32'd0);
    hold(3'd5, 6);
    hold(3'd6, 1);
    hold(3'd7, 1);

    cur = "R1";
    hold(3'd3, 3);
    do_reset();
    step(1'b0, 3'd0, 1'b0, 32'd0);
    step(1'b1, 3'd0, 1'b0, 32'd0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_bad++;
        n_run++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule